// File: doc/BRIEF.md
# Banked-Configuration GPIO Port Controller

A bus-attached controller for a group of 8-bit general-purpose I/O ports. Each port occupies a single address. A write to that address, or a read from it, reaches one of five per-port registers: the output latch, direction, input threshold select, weak pull-up enable or Schmitt trigger enable. A small mode register picks which one. The CPU first loads the mode and then accesses the port addresses, so the configuration space takes no extra address slots.

The register bits go straight to the pad models as per-pin control lines. Output enable is derived from the direction bits. The other controls leave the block in their active-low register form. Data reads return either the synchronized pin levels or the output latch, and a read-select input chooses between them. A parameter builds a reduced variant in which port A keeps only its low pins, and the missing pins behave as if pulled high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is held and after it is released, every port register bit (latch, direction, level, pull-up, Schmitt) is 1 and the mode is 0. Hence oe_o is all 0 and dout_o, pu_n_o, lvl_o and st_n_o are all 1.
- R2: Port k sits at address BASE_ADDR+k, which is 05h to 09h by default. A write to any other address changes nothing, and a read from any other address returns 0.
- R3: A mode_wr_i strobe loads wdata_i[2:0] into the mode. The codes are 0 = latch, 1 = direction, 2 = level, 3 = pull-up and 4 = Schmitt. A bus_wr_i write updates the register that the mode selects at the rising edge where the strobe is sampled. With codes 5 to 7, writes do nothing and reads return 0.
- R4: A direction bit of 0 makes its pin an output (oe_o high), and 1 makes it Hi-Z. Pin p of port k is bit k*8+p of every pad vector, with register bit 0 on the lowest pin.
- R5: lvl_o mirrors the level register (1 = TTL, 0 = CMOS). pu_n_o mirrors the pull-up register (0 = pull-up on).
- R6: Ports B to E have a Schmitt register that drives st_n_o (0 = enabled). Port A has none: its st_n_o bits stay 1, mode-4 writes to port A are ignored, and mode-4 reads of port A return 0.
- R7: dout_o shows the latch. A latch write drives a pin only where oe_o is high.
- R8: In mode 0, a read returns the synchronized pins when rd_pins_i is 1 and the latch when it is 0.
- R9: A pin change shows up in a pin read after the second rising edge and not after the first.
- R10: With PORTA_PINS=4, the missing pins 7:4 of port A read 1 in every mode-0 to mode-3 read, ignore writes, and never drive.
- R11: In modes 1 to 4, a read of a port address returns the register selected for that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Load mode from wdata_i[2:0] |
| bus_wr_i | input | 1 | Write strobe for the port addresses |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | PORT_W | Write data |
| rd_pins_i | input | 1 | Data read source: 1 = pins, 0 = latch |
| rdata_o | output | PORT_W | Combinational read data |
| pin_i | input | NUM_PORTS*PORT_W | Pad input levels |
| oe_o | output | NUM_PORTS*PORT_W | Output enable, active high |
| dout_o | output | NUM_PORTS*PORT_W | Output latch value |
| pu_n_o | output | NUM_PORTS*PORT_W | Pull-up enable, active low |
| lvl_o | output | NUM_PORTS*PORT_W | Threshold select, 1 = TTL |
| st_n_o | output | NUM_PORTS*PORT_W | Schmitt enable, active low |

## Verification
The bench builds two copies side by side on the same bus, and both use five ports. One keeps all eight port A pins. The other sets PORTA_PINS=4, which exposes the forced-high upper nibble, the masked writes and the output enables held off on missing pins. The full copy covers the mode and address decode, the port A Schmitt gap and the two-edge pin latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_LVL  = 3'd2,
    SEL_PULL = 3'd3,
    SEL_SCHM = 3'd4
  } bank_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORT_W  = 8,
  parameter bit          HAS_SCHM = 1'b1,
  parameter logic [PORT_W-1:0] PRESENT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  bank_sel_e         sel_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] data_o,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] lvl_o,
  output logic [PORT_W-1:0] pull_o,
  output logic [PORT_W-1:0] schm_o
);
  // absent pins hold 1
  logic [PORT_W-1:0] wval;
  assign wval = wdata_i | ~PRESENT;

  logic [PORT_W-1:0] data_q, dir_q, lvl_q, pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '1;
      dir_q  <= '1;
      lvl_q  <= '1;
      pull_q <= '1;
    end else if (wr_i) begin
      case (sel_i)
        SEL_DATA: data_q <= wval;
        SEL_DIR:  dir_q  <= wval;
        SEL_LVL:  lvl_q  <= wval;
        SEL_PULL: pull_q <= wval;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_SCHM) begin : g_schm
      logic [PORT_W-1:0] schm_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) schm_q <= '1;
        else if (wr_i && sel_i == SEL_SCHM) schm_q <= wval;
      end
      assign schm_o = schm_q;
    end else begin : g_no_schm
      assign schm_o = '1;
    end
  endgenerate

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign lvl_o  = lvl_q;
  assign pull_o = pull_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 5,
  parameter int unsigned PORTA_PINS  = PORT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mode_wr_i,
  input  logic                          bus_wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [PORT_W-1:0]             wdata_i,
  input  logic                          rd_pins_i,
  output logic [PORT_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  output logic [NUM_PORTS*PORT_W-1:0]   oe_o,
  output logic [NUM_PORTS*PORT_W-1:0]   dout_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pu_n_o,
  output logic [NUM_PORTS*PORT_W-1:0]   lvl_o,
  output logic [NUM_PORTS*PORT_W-1:0]   st_n_o
);
  localparam int unsigned TOT_W = NUM_PORTS * PORT_W;
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [PORT_W-1:0] A_MASK =
    (PORTA_PINS >= PORT_W) ? '1 : PORT_W'((64'd1 << PORTA_PINS) - 64'd1);

  // mode register
  bank_sel_e mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= SEL_DATA;
    else if (mode_wr_i) mode_q <= bank_sel_e'(wdata_i[SEL_W-1:0]);
  end

  // address decode
  logic [ADDR_W-1:0] offset;
  logic              in_range;
  logic [IDX_W-1:0]  port_idx;
  assign offset   = addr_i - ADDR_W'(BASE_ADDR);
  assign in_range = (addr_i >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NUM_PORTS));
  assign port_idx = offset[IDX_W-1:0];

  logic [TOT_W-1:0] pin_sync;
  gpio_pin_sync #(.WIDTH(TOT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  logic [PORT_W-1:0] data_arr [NUM_PORTS];
  logic [PORT_W-1:0] dir_arr  [NUM_PORTS];
  logic [PORT_W-1:0] lvl_arr  [NUM_PORTS];
  logic [PORT_W-1:0] pull_arr [NUM_PORTS];
  logic [PORT_W-1:0] schm_arr [NUM_PORTS];
  logic [PORT_W-1:0] pin_arr  [NUM_PORTS];
  logic [PORT_W-1:0] mask_arr [NUM_PORTS];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam logic [PORT_W-1:0] MASK = (k == 0) ? A_MASK : '1;
    logic wr_hit;
    assign wr_hit = bus_wr_i && in_range && (port_idx == IDX_W'(k));

    gpio_port_regs #(
      .PORT_W  (PORT_W),
      .HAS_SCHM(k != 0),
      .PRESENT (MASK)
    ) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_hit),
      .sel_i  (mode_q),
      .wdata_i(wdata_i),
      .data_o (data_arr[k]),
      .dir_o  (dir_arr[k]),
      .lvl_o  (lvl_arr[k]),
      .pull_o (pull_arr[k]),
      .schm_o (schm_arr[k])
    );

    assign mask_arr[k] = MASK;
    assign pin_arr[k]  = pin_sync[k*PORT_W +: PORT_W];

    assign oe_o  [k*PORT_W +: PORT_W] = ~dir_arr[k] & MASK;
    assign dout_o[k*PORT_W +: PORT_W] = data_arr[k];
    assign pu_n_o[k*PORT_W +: PORT_W] = pull_arr[k];
    assign lvl_o [k*PORT_W +: PORT_W] = lvl_arr[k];
    assign st_n_o[k*PORT_W +: PORT_W] = schm_arr[k];
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (in_range) begin
      case (mode_q)
        SEL_DATA: rdata_o = rd_pins_i ? (pin_arr[port_idx] | ~mask_arr[port_idx])
                                      : data_arr[port_idx];
        SEL_DIR:  rdata_o = dir_arr[port_idx];
        SEL_LVL:  rdata_o = lvl_arr[port_idx];
        SEL_PULL: rdata_o = pull_arr[port_idx];
        SEL_SCHM: rdata_o = (port_idx == '0) ? '0 : schm_arr[port_idx];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 5
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        bus_wr_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [PORT_W-1:0]           wdata_i,
  input logic [2:0]                  mode_q_i,
  input logic [PORT_W-1:0]           rdata_o,
  input logic [NUM_PORTS*PORT_W-1:0] oe_o,
  input logic [NUM_PORTS*PORT_W-1:0] dout_o,
  input logic [NUM_PORTS*PORT_W-1:0] pu_n_o,
  input logic [NUM_PORTS*PORT_W-1:0] lvl_o,
  input logic [NUM_PORTS*PORT_W-1:0] st_n_o
);
  // R3
  write_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i |=> ($stable(oe_o) && $stable(dout_o) && $stable(pu_n_o)
                   && $stable(lvl_o) && $stable(st_n_o)));

  // R3
  bad_mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && mode_q_i > 3'd4) |=> ($stable(oe_o) && $stable(dout_o)
                   && $stable(pu_n_o) && $stable(lvl_o) && $stable(st_n_o)));

  // R3
  bad_mode_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i > 3'd4) |-> (rdata_o == '0));

  // R2
  below_range_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < ADDR_W'(BASE_ADDR)) |-> (rdata_o == '0));

  // R6
  porta_no_schm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_n_o[PORT_W-1:0] == '1);

  // R4
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && mode_q_i == 3'd1 && addr_i == ADDR_W'(BASE_ADDR + 1))
      |=> (oe_o[2*PORT_W-1:PORT_W] == ~$past(wdata_i)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PORT_W   (PORT_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bus_wr_i(bus_wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .mode_q_i(mode_q),
  .rdata_o (rdata_o),
  .oe_o    (oe_o),
  .dout_o  (dout_o),
  .pu_n_o  (pu_n_o),
  .lvl_o   (lvl_o),
  .st_n_o  (st_n_o)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_pins = 1'b0;
  logic [39:0] pins = '0;

  logic [7:0]  f_rdata, r_rdata;
  logic [39:0] f_oe, f_dout, f_pu, f_lvl, f_st;
  logic [39:0] r_oe, r_dout, r_pu, r_lvl, r_st;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .bus_wr_i(bus_wr),
    .addr_i(addr), .wdata_i(wdata), .rd_pins_i(rd_pins), .rdata_o(f_rdata),
    .pin_i(pins), .oe_o(f_oe), .dout_o(f_dout), .pu_n_o(f_pu),
    .lvl_o(f_lvl), .st_n_o(f_st)
  );

  gpio_bank_ctrl #(.PORTA_PINS(4)) dut_rd_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .bus_wr_i(bus_wr),
    .addr_i(addr), .wdata_i(wdata), .rd_pins_i(rd_pins), .rdata_o(r_rdata),
    .pin_i(pins), .oe_o(r_oe), .dout_o(r_dout), .pu_n_o(r_pu),
    .lvl_o(r_lvl), .st_n_o(r_st)
  );

  // {mode, addr, wdata, expected read-back}
  localparam logic [31:0] VEC [10] = '{
    {8'd0, 8'h05, 8'hA5, 8'hA5},  // R3 latch A
    {8'd1, 8'h05, 8'h0F, 8'h0F},  // R11 dir A
    {8'd2, 8'h06, 8'h3C, 8'h3C},  // R11 level B
    {8'd3, 8'h07, 8'h81, 8'h81},  // R11 pull-up C
    {8'd4, 8'h08, 8'h55, 8'h55},  // R11 Schmitt D
    {8'd4, 8'h05, 8'h00, 8'h00},  // R6 no Schmitt on A
    {8'd5, 8'h09, 8'h00, 8'h00},  // R3 invalid mode
    {8'd0, 8'h0A, 8'h12, 8'h00},  // R2 above range
    {8'd0, 8'h04, 8'h12, 8'h00},  // R2 below range
    {8'd1, 8'h09, 8'hF0, 8'hF0}   // R11 dir E
  };

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk);
    wdata = m; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    #5;
    // R1 during reset
    check("R1 oe in reset", f_oe, 40'h0);
    check("R1 dout in reset", f_dout, {40{1'b1}});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 pu_n after reset", f_pu, {40{1'b1}});
    check("R1 lvl after reset", f_lvl, {40{1'b1}});
    check("R1 st_n after reset", f_st, {40{1'b1}});
    check("R1 reduced oe after reset", r_oe, 40'h0);
    read_at(8'h05);
    check("R1 latch A read", {32'h0, f_rdata}, 40'hFF);

    for (int i = 0; i < 10; i++) begin
      set_mode(VEC[i][31:24]);
      bus_write(VEC[i][23:16], VEC[i][15:8]);
      read_at(VEC[i][23:16]);
      check($sformatf("R3 R11 table row %0d", i), {32'h0, f_rdata}, {32'h0, VEC[i][7:0]});
    end

    // pad checks after table
    check("R7 dout A", {32'h0, f_dout[7:0]}, 40'hA5);
    check("R4 oe A", {32'h0, f_oe[7:0]}, 40'hF0);
    check("R4 oe E", {32'h0, f_oe[39:32]}, 40'h0F);
    check("R4 oe B-D hi-z", {16'h0, f_oe[31:8]}, 40'h0);
    check("R5 lvl B", {32'h0, f_lvl[15:8]}, 40'h3C);
    check("R5 pu_n C", {32'h0, f_pu[23:16]}, 40'h81);
    check("R6 st_n D", {32'h0, f_st[31:24]}, 40'h55);
    check("R6 st_n A", {32'h0, f_st[7:0]}, 40'hFF);
    check("R2 out-of-range no effect", {32'h0, f_dout[39:32]}, 40'hFF);

    // R7 latch write on Hi-Z port B
    set_mode(8'd0);
    bus_write(8'h06, 8'h33);
    check("R7 dout B", {32'h0, f_dout[15:8]}, 40'h33);
    check("R7 oe B stays off", {32'h0, f_oe[15:8]}, 40'h0);

    // R8 and R9
    @(negedge clk);
    pins[15:8] = 8'h5A;
    rd_pins = 1'b1;
    read_at(8'h06);
    @(negedge clk);
    read_at(8'h06);
    check("R9 one edge not yet", {32'h0, f_rdata}, 40'h00);
    @(negedge clk);
    read_at(8'h06);
    check("R9 two edges visible", {32'h0, f_rdata}, 40'h5A);
    check("R8 pin source", {32'h0, f_rdata}, 40'h5A);
    rd_pins = 1'b0;
    read_at(8'h06);
    check("R8 latch source", {32'h0, f_rdata}, 40'h33);

    // R10 reduced port A
    bus_write(8'h05, 8'h00);
    read_at(8'h05);
    check("R10 reduced latch read", {32'h0, r_rdata}, 40'hF0);
    check("R10 full latch read", {32'h0, f_rdata}, 40'h00);
    check("R10 reduced dout A", {32'h0, r_dout[7:0]}, 40'hF0);
    rd_pins = 1'b1;
    read_at(8'h05);
    check("R10 reduced pin read", {32'h0, r_rdata}, 40'hF0);
    rd_pins = 1'b0;
    set_mode(8'd1);
    bus_write(8'h05, 8'h00);
    check("R10 reduced oe A", {32'h0, r_oe[7:0]}, 40'h0F);
    check("R4 full oe A", {32'h0, f_oe[7:0]}, 40'hFF);
    read_at(8'h05);
    check("R10 reduced dir read", {32'h0, r_rdata}, 40'hF0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule